// File: doc/BRIEF.md
# Single-Port Static Memory with Per-Word Write Tracking

This block is a single-port static memory with three active-low control pins: select, write and output enable. It has separate input and output data buses and a parameterised address width and word width. A system clock samples the control pins on every rising edge, so the whole block is synthesizable. A word is written on each rising edge while select and write are both low.

Each word also carries a one-bit written flag, and reset clears every flag. A read of a word whose flag is clear raises an invalid indication instead of returning stale content. The read result, the drive enable and the invalid bit pass through a delay of `LAT` clock cycles, so the block can model a slow part. A top level uses the drive-enable output to build a shared tri-state data bus.

The control pins are plain levels. The data port has no valid/ready handshake and applies no back-pressure: every sampled write is accepted, and every read result appears exactly `LAT` cycles later.

Top module: `sram_wtrack`

## Requirements
- R1: While `cs_n` is high, `q_drive` is low, whatever `we_n`, `oe_n`, `addr` and `din` are.
- R2: With `cs_n` low and both `we_n` and `oe_n` high, `q_drive` is low.
- R3: With `cs_n` and `we_n` both low, `din` is stored at `addr` on the rising edge, whatever `oe_n` is, and `q_drive` stays low.
- R4: With `cs_n` low, `we_n` high and `oe_n` low, `q_drive` is high. If the addressed word has been written since reset, `q` carries that word and `q_invalid` is 0.
- R5: While `cs_n` and `we_n` stay low, each rising edge stores `din` at the address present at that edge. Changing `addr` during a held write therefore writes every address it passes through.
- R6: A read of a word not written since reset gives `q_invalid` = 1 with `q_drive` = 1. `q` then carries no defined value: all-X in simulation, don't-care in hardware.
- R7: Reset (`rst_n` low, asynchronous) clears every written flag and holds `q_drive`, `q_invalid` and `q` at 0. A write requested while reset is asserted is ignored.
- R8: `q`, `q_drive` and `q_invalid` show the response to the pins sampled `LAT` rising edges earlier. With `LAT` = 0 the response is combinational.
- R9: Whenever `q_drive` is low, `q` is all zeros and `q_invalid` is 0.
- R10: A read in the cycle right after a write to the same address returns the newly written word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write enable |
| oe_n | input | 1 | Active-low output enable |
| addr | input | AW | Word address |
| din | input | DW | Write data |
| q | output | DW | Read data, after `LAT` cycles |
| q_drive | output | 1 | High when a top level should drive `q` onto the shared bus |
| q_invalid | output | 1 | High when the read word was never written since reset |

## Verification
The hardest state to reach from the ports is a word whose flag has been cleared by a second reset while its storage still holds an old value. A visible read of stale data is exactly the fault this block exists to prevent. The bench writes several addresses, then issues a reset during which it drives an active write to yet another address. After reset it reads the earlier addresses and the address written during reset, and expects the invalid indication for all of them. Held writes with a moving address and back-to-back write/read pairs cover the remaining timing cases. A stretch of random pin patterns runs alongside these directed cases, and a cycle model with an `LAT`-deep queue checks the result on every clock.

// File: rtl/sram_wtrack_pkg.sv
package sram_wtrack_pkg;
  typedef enum logic [1:0] {
    PM_DESEL = 2'd0,
    PM_OFF   = 2'd1,
    PM_WRITE = 2'd2,
    PM_READ  = 2'd3
  } pin_mode_e;

  function automatic pin_mode_e decode_pins(input logic cs_n, input logic we_n,
                                            input logic oe_n);
    pin_mode_e m;
    if (cs_n)       m = PM_DESEL;
    else if (!we_n) m = PM_WRITE;
    else if (!oe_n) m = PM_READ;
    else            m = PM_OFF;
    return m;
  endfunction
endpackage

// File: rtl/sram_mode_dec.sv
module sram_mode_dec
  import sram_wtrack_pkg::*;
(
  input  logic rst_n,
  input  logic cs_n,
  input  logic we_n,
  input  logic oe_n,
  output logic wr_en,
  output logic rd_en
);
  pin_mode_e mode;

  always_comb begin
    mode  = decode_pins(cs_n, we_n, oe_n);
    // nothing is written or driven while reset is asserted
    wr_en = rst_n && (mode == PM_WRITE);
    rd_en = rst_n && (mode == PM_READ);
  end
endmodule

// File: rtl/sram_store.sv
module sram_store #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] rd_word
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= din;
  end

  assign rd_word = mem[addr];
endmodule

// File: rtl/sram_flags.sv
module sram_flags #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [AW-1:0] addr,
  output logic          written
);
  localparam int DEPTH = 1 << AW;

  logic [DEPTH-1:0] flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flags       <= '0;
    else if (set_en) flags[addr] <= 1'b1;
  end

  assign written = flags[addr];
endmodule

// File: rtl/sram_out_delay.sv
module sram_out_delay #(
  parameter int W   = 10,
  parameter int LAT = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (LAT == 0) begin : g_comb
      assign q = d;
    end else begin : g_pipe
      logic [W-1:0] stg [LAT];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < LAT; i++) stg[i] <= '0;
        end else begin
          stg[0] <= d;
          for (int i = 1; i < LAT; i++) stg[i] <= stg[i-1];
        end
      end
      assign q = stg[LAT-1];
    end
  endgenerate
endmodule

// File: rtl/sram_wtrack.sv
module sram_wtrack #(
  parameter int AW  = 6,
  parameter int DW  = 8,
  parameter int LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] q,
  output logic          q_drive,
  output logic          q_invalid
);
  localparam int BUS_W = DW + 2;

  logic          wr_en, rd_en, written;
  logic [DW-1:0] rd_word;
  logic          core_oe, core_inv;
  logic [DW-1:0] core_data;
  logic [BUS_W-1:0] core_bus, out_bus;

  sram_mode_dec u_dec (
    .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
    .wr_en(wr_en), .rd_en(rd_en)
  );

  sram_store #(.AW(AW), .DW(DW)) u_store (
    .clk(clk), .wr_en(wr_en), .addr(addr), .din(din), .rd_word(rd_word)
  );

  sram_flags #(.AW(AW)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_en(wr_en), .addr(addr), .written(written)
  );

  always_comb begin
    core_oe  = rd_en;
    core_inv = rd_en && !written;
    if (!rd_en)       core_data = '0;
    else if (written) core_data = rd_word;
    else              core_data = {DW{1'bx}};
  end

  assign core_bus = {core_oe, core_inv, core_data};

  sram_out_delay #(.W(BUS_W), .LAT(LAT)) u_dly (
    .clk(clk), .rst_n(rst_n), .d(core_bus), .q(out_bus)
  );

  assign q_drive   = out_bus[BUS_W-1];
  assign q_invalid = out_bus[BUS_W-2];
  assign q         = out_bus[DW-1:0];
endmodule

// File: rtl/sram_wtrack_chk.sv
module sram_wtrack_chk #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          we_n,
  input logic          oe_n,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] din,
  input logic [DW-1:0] q,
  input logic          q_drive,
  input logic          q_invalid,
  input logic          core_oe,
  input logic          core_inv,
  input logic [DW-1:0] core_data
);
  p_desel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !core_oe);

  p_outoff_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && we_n && oe_n) |-> !core_oe);

  p_write_hiz_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !we_n) |-> !core_oe);

  p_read_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && we_n && !oe_n) |-> core_oe);

  p_readback_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(!cs_n && !we_n) && !cs_n && we_n && !oe_n &&
     addr == $past(addr)) |-> (!core_inv && core_data == $past(din)));

  p_quiet_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !q_drive |-> (q == '0 && !q_invalid));

  p_inv_driven_r6: assert property (@(posedge clk) disable iff (!rst_n)
    q_invalid |-> q_drive);
endmodule

bind sram_wtrack sram_wtrack_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
  .addr(addr), .din(din), .q(q), .q_drive(q_drive), .q_invalid(q_invalid),
  .core_oe(core_oe), .core_inv(core_inv), .core_data(core_data)
);

// File: tb/sram_wtrack_test.sv
module sram_wtrack_test;
  localparam int AW  = 6;
  localparam int DW  = 8;
  localparam int LAT = 2;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] q;
  logic q_drive, q_invalid;

  always #5 clk = ~clk;

  sram_wtrack #(.AW(AW), .DW(DW), .LAT(LAT)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .q(q), .q_drive(q_drive), .q_invalid(q_invalid)
  );

  // behavioural reference: word store, written flags, response queue
  logic [DW-1:0] m_mem [DEPTH];
  bit            m_flag [DEPTH];
  logic [DW+1:0] exp_q [$];
  string         tag_q [$];
  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  task automatic refill();
    exp_q.delete();
    tag_q.delete();
    for (int i = 0; i < LAT; i++) begin
      exp_q.push_back('0);
      tag_q.push_back("R7");
    end
  endtask

  task automatic compare(input logic [DW+1:0] e, input string tag);
    bit bad = 0;
    vectors++;
    if (q_drive !== e[DW+1] || q_invalid !== e[DW]) bad = 1;
    else if (e[DW+1] && !e[DW] && q !== e[DW-1:0]) bad = 1;
    else if (!e[DW+1] && q !== '0) bad = 1;
    if (bad) begin
      miscompares++;
      $display("FAIL %s R8 R9 t=%0t: got drive=%b inv=%b q=%h, expected drive=%b inv=%b q=%h",
               tag, $time, q_drive, q_invalid, q, e[DW+1], e[DW], e[DW-1:0]);
    end
  endtask

  task automatic step(input logic c, input logic w, input logic o,
                      input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input string phase);
    logic [DW+1:0] e;
    string t;
    @(negedge clk);
    cs_n = c; we_n = w; oe_n = o; addr = a; din = d;
    #1;
    if (c)            begin e = '0; t = "R1"; end
    else if (!w)      begin e = '0; t = "R3"; end
    else if (o)       begin e = '0; t = "R2"; end
    else if (m_flag[a]) begin e = {1'b1, 1'b0, m_mem[a]}; t = "R4"; end
    else              begin e = {1'b1, 1'b1, {DW{1'b0}}}; t = "R6"; end
    exp_q.push_back(e);
    tag_q.push_back({t, "/", phase});
    #2;
    begin
      logic [DW+1:0] ex;
      string tg;
      ex = exp_q.pop_front();
      tg = tag_q.pop_front();
      compare(ex, tg);
    end
    @(posedge clk);
    if (!c && !w) begin
      m_mem[a]  = d;
      m_flag[a] = 1'b1;
    end
  endtask

  // reset with chosen pin values held during it (writes must be ignored)
  task automatic do_reset(input logic c, input logic w, input logic [AW-1:0] a,
                          input logic [DW-1:0] d);
    @(negedge clk);
    rst_n = 1'b0; cs_n = c; we_n = w; oe_n = 1'b1; addr = a; din = d;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      #3 compare('0, "R7");
    end
    for (int i = 0; i < DEPTH; i++) m_flag[i] = 1'b0;
    @(negedge clk);
    rst_n = 1'b1; cs_n = 1'b1; we_n = 1'b1;
    refill();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got hang, expected completion");
      finish_run();
    end
  end

  initial begin
    do_reset(1'b1, 1'b1, '0, '0);
    // unwritten read
    step(0, 1, 0, 6'd5, 8'h00, "R6");
    // writes with oe_n high and low
    step(0, 0, 1, 6'd5, 8'hA5, "R3");
    step(0, 0, 0, 6'd6, 8'h3C, "R3");
    step(0, 1, 0, 6'd5, 8'h00, "R4");
    step(0, 1, 0, 6'd6, 8'hFF, "R4");
    // read directly after write
    step(0, 0, 1, 6'd7, 8'h81, "R10");
    step(0, 1, 0, 6'd7, 8'h00, "R10");
    step(0, 0, 1, 6'd7, 8'h18, "R10");
    step(0, 1, 0, 6'd7, 8'h00, "R10");
    // held write, moving address
    for (int i = 0; i < 8; i++) step(0, 0, 1, AW'(10 + i), DW'(8'h40 + i), "R5");
    for (int i = 0; i < 8; i++) step(0, 1, 0, AW'(10 + i), 8'h00, "R5");
    // deselect with active-looking pins, output disabled
    step(1, 0, 0, 6'd20, 8'h77, "R1");
    step(1, 1, 0, 6'd5, 8'h00, "R1");
    step(0, 1, 0, 6'd20, 8'h00, "R1");
    step(0, 1, 1, 6'd5, 8'h00, "R2");
    step(0, 1, 1, 6'd6, 8'h00, "R9");
    // latency: alternate read/idle
    for (int i = 0; i < 6; i++) step(0, 1, i[0], 6'd5, 8'h00, "R8");
    // random traffic
    for (int i = 0; i < 400; i++)
      step(1'($urandom_range(0, 3) == 0), 1'($urandom), 1'($urandom),
           AW'($urandom_range(0, 15)), DW'($urandom), "R8");
    // second reset with a write pending, then stale addresses read invalid
    step(0, 0, 1, 6'd30, 8'h5A, "R3");
    do_reset(1'b0, 1'b0, 6'd40, 8'hC3);
    step(0, 1, 0, 6'd40, 8'h00, "R7");
    step(0, 1, 0, 6'd5, 8'h00, "R7");
    step(0, 1, 0, 6'd30, 8'h00, "R7");
    step(0, 0, 1, 6'd30, 8'h11, "R7");
    step(0, 1, 0, 6'd30, 8'h00, "R7");
    for (int i = 0; i < LAT + 1; i++) step(1, 1, 1, '0, '0, "R1");
    done = 1;
    finish_run();
  end
endmodule